// File: doc/BRIEF.md
# Slotted Audio Frame Serializer

This block is the codec-side transmitter of a time-slotted serial audio link. It runs entirely on the link bit clock, which is nominally 12.288 MHz with a frame every 256 bits (48 kHz, about 20.8 us). The controller marks each frame by raising a SYNC line in step with the rising bit-clock edge. The serializer samples SYNC on falling edges. When a falling-edge sample shows a low-to-high change, the serializer starts a frame and shifts out 256 bits, one per rising edge, so that the far end can sample each bit on the following falling edge.

A frame starts with a 16-bit tag slot. The tag holds a ready flag, then one valid flag per data slot, then three zero bits. Twelve 20-bit data slots follow the tag, each sent most significant bit first. Bits of any data slot whose valid flag is clear are sent as zero. When the ready flag is low, the whole frame is zero.

The slot words, valid flags and ready flag come from parallel register inputs. They are captured into a shadow copy at the first rising edge of each frame, so changes made during a frame take effect in the next frame.

Top module: `afs_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, sdata_o is 0.
- R2: A frame starts only at a falling bit-clock edge where sync_i is sampled 1 and the previous falling-edge sample was 0. Frame bit 0 is launched at the next rising edge. Holding sync_i high does not start another frame.
- R3: Frame bit 0 (the first bit of the tag slot) equals the ready flag.
- R4: Frame bits 1 to 12 carry the valid flags of slots 1 to 12 in that order (1 = valid data), and frame bits 13 to 15 are 0.
- R5: Data slot k (k = 1..12) occupies frame bits 16+20*(k-1) to 35+20*(k-1) and is sent MSB first. Slot k is read from slot_data_i[20*(k-1) +: 20], and its valid flag is slot_valid_i[k-1].
- R6: Every bit of a data slot whose valid flag is 0 is sent as 0.
- R7: When the captured ready flag is 0, all 256 bits of the frame are 0.
- R8: Ready, valid flags and slot words are captured at the rising edge that launches frame bit 0. Changes made after that edge do not affect the current frame, and they appear in the next frame.
- R9: After frame bit 255, sdata_o returns to 0 until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data launched on rising edge, SYNC sampled on falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync, changes with rising bit-clock edge |
| ready_i | input | 1 | Codec ready flag for the next frame |
| slot_valid_i | input | 12 | Valid flag per data slot, bit k-1 for slot k |
| slot_data_i | input | 240 | Twelve 20-bit slot words, slot k at [20*(k-1) +: 20] |
| sdata_o | output | 1 | Serial frame output |

## Verification
The bench builds the block with its default parameters: twelve 20-bit data slots after a 16-bit tag, giving the full 256-bit frame. With these values every slot boundary, the tag padding bits and the transition from the last data bit back to idle can each be checked bit by bit against positions computed from the requirements. The chosen frames cover full validity, a mixed valid mask over all-ones data, a frame with ready low, a frame with an all-zero mask, and a change of inputs in the middle of a frame.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int unsigned NUM_SLOTS_DEF = 12;
  localparam int unsigned SLOT_W_DEF    = 20;
  localparam int unsigned TAG_W_DEF     = 16;

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/afs_sync_detect.sv
module afs_sync_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic start_o
);
  logic sync_prev_q, start_q;

  // falling-edge sample: both ends agree on frame start here
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      sync_prev_q <= sync_i;
      start_q     <= sync_i & ~sync_prev_q;
    end
  end

  assign start_o = start_q;

  assert_single_start_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
endmodule

// File: rtl/afs_seq.sv
module afs_seq #(
  parameter int unsigned NUM_SLOTS = afs_pkg::NUM_SLOTS_DEF,
  parameter int unsigned SLOT_W    = afs_pkg::SLOT_W_DEF,
  parameter int unsigned TAG_W     = afs_pkg::TAG_W_DEF,
  localparam int unsigned SW = $clog2(NUM_SLOTS + 1),
  localparam int unsigned BW = $clog2(afs_pkg::max_w(TAG_W, SLOT_W))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          active_o,
  output logic [SW-1:0] slot_o,
  output logic [BW-1:0] bit_o
);
  localparam logic [BW-1:0] TAG_LAST  = BW'(TAG_W - 1);
  localparam logic [BW-1:0] SLOT_LAST = BW'(SLOT_W - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS);

  logic          active_q;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic          slot_end;

  assign slot_end = (slot_q == '0) ? (bit_q == TAG_LAST) : (bit_q == SLOT_LAST);

  // holds position of the next bit to launch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      bit_q    <= BW'(1);
    end else if (active_q) begin
      if (slot_end) begin
        bit_q  <= '0;
        slot_q <= slot_q + SW'(1);
        if (slot_q == LAST_SLOT) active_q <= 1'b0;
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign bit_o    = bit_q;

  assert_pos_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (int'(slot_q) <= int'(NUM_SLOTS)) &&
                 (int'(bit_q) < int'((slot_q == '0) ? TAG_W : SLOT_W)));
  assert_end_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && slot_end && slot_q == LAST_SLOT && !start_i) |=> !active_q);
endmodule

// File: rtl/afs_shadow.sv
module afs_shadow #(
  parameter int unsigned NUM_SLOTS = afs_pkg::NUM_SLOTS_DEF,
  parameter int unsigned SLOT_W    = afs_pkg::SLOT_W_DEF,
  localparam int unsigned DW = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  logic                 ready_i,
  input  logic [NUM_SLOTS-1:0] valid_i,
  input  logic [DW-1:0]        data_i,
  output logic                 ready_o,
  output logic [NUM_SLOTS-1:0] valid_o,
  output logic [DW-1:0]        data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      valid_o <= '0;
      data_o  <= '0;
    end else if (capture_i) begin
      ready_o <= ready_i;
      valid_o <= valid_i;
      data_o  <= data_i;
    end
  end

  assert_shadow_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(data_o) && $stable(valid_o) && $stable(ready_o));
endmodule

// File: rtl/afs_slot_mux.sv
module afs_slot_mux #(
  parameter int unsigned NUM_SLOTS = afs_pkg::NUM_SLOTS_DEF,
  parameter int unsigned SLOT_W    = afs_pkg::SLOT_W_DEF,
  parameter int unsigned TAG_W     = afs_pkg::TAG_W_DEF,
  localparam int unsigned SW = $clog2(NUM_SLOTS + 1),
  localparam int unsigned BW = $clog2(afs_pkg::max_w(TAG_W, SLOT_W)),
  localparam int unsigned DW = NUM_SLOTS * SLOT_W
) (
  input  logic                 ready_i,
  input  logic [NUM_SLOTS-1:0] valid_i,
  input  logic [DW-1:0]        data_i,
  input  logic [SW-1:0]        slot_i,
  input  logic [BW-1:0]        bit_i,
  output logic                 bit_o
);
  int unsigned s, b;

  always_comb begin
    s     = int'(slot_i);
    b     = int'(bit_i);
    bit_o = 1'b0;
    if (s == 0) begin
      if (b == 0)              bit_o = ready_i;
      else if (b <= NUM_SLOTS) bit_o = valid_i[b-1];
    end else if (s <= NUM_SLOTS && b < SLOT_W) begin
      // MSB first, invalid slots stuffed with zero
      bit_o = valid_i[s-1] & data_i[(s-1)*SLOT_W + (SLOT_W-1-b)];
    end
    bit_o = bit_o & ready_i;
  end
endmodule

// File: rtl/afs_serializer.sv
module afs_serializer #(
  parameter int unsigned NUM_SLOTS = afs_pkg::NUM_SLOTS_DEF,
  parameter int unsigned SLOT_W    = afs_pkg::SLOT_W_DEF,
  parameter int unsigned TAG_W     = afs_pkg::TAG_W_DEF,
  localparam int unsigned SW = $clog2(NUM_SLOTS + 1),
  localparam int unsigned BW = $clog2(afs_pkg::max_w(TAG_W, SLOT_W)),
  localparam int unsigned DW = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 ready_i,
  input  logic [NUM_SLOTS-1:0] slot_valid_i,
  input  logic [DW-1:0]        slot_data_i,
  output logic                 sdata_o
);
  logic                 start;
  logic                 active;
  logic [SW-1:0]        slot;
  logic [BW-1:0]        bit_pos;
  logic                 sh_ready;
  logic [NUM_SLOTS-1:0] sh_valid;
  logic [DW-1:0]        sh_data;
  logic                 mux_bit;
  logic                 sdata_q;

  afs_sync_detect u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .start_o (start)
  );

  afs_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_o (active),
    .slot_o   (slot),
    .bit_o    (bit_pos)
  );

  afs_shadow #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (start),
    .ready_i   (ready_i),
    .valid_i   (slot_valid_i),
    .data_i    (slot_data_i),
    .ready_o   (sh_ready),
    .valid_o   (sh_valid),
    .data_o    (sh_data)
  );

  afs_slot_mux #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_mux (
    .ready_i (sh_ready),
    .valid_i (sh_valid),
    .data_i  (sh_data),
    .slot_i  (slot),
    .bit_i   (bit_pos),
    .bit_o   (mux_bit)
  );

  // bit 0 comes straight from the live ready flag, shadow loads on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sdata_q <= 1'b0;
    else if (start)  sdata_q <= ready_i;
    else if (active) sdata_q <= mux_bit;
    else             sdata_q <= 1'b0;
  end

  assign sdata_o = sdata_q;

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !start) |=> !sdata_o);
  assert_ready_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (sdata_o == $past(ready_i)));
  assert_not_ready_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !start && !sh_ready) |=> !sdata_o);
endmodule

// File: tb/afs_serializer_test.sv
`timescale 1ns/1ps
module afs_serializer_test;
  localparam int NS = 12;
  localparam int SWD = 20;
  localparam int TW = 16;
  localparam int FBITS = TW + NS * SWD;
  localparam int TAIL = 4;

  typedef struct { logic b; string tag; int pos; } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0;
  logic ready_i = 1'b0;
  logic [NS-1:0] slot_valid_i = '0;
  logic [NS*SWD-1:0] slot_data_i = '0;
  logic sdata_o;

  int checks = 0;
  int fails = 0;
  exp_t q[$];
  event go;

  always #2.5 clk = ~clk;

  afs_serializer uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .ready_i(ready_i),
    .slot_valid_i(slot_valid_i), .slot_data_i(slot_data_i), .sdata_o(sdata_o)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int pos);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s bit %0d: actual %b expected %b", tag, pos, act, exp);
    end
  endtask

  // expected frame from requirements, then idle tail
  task automatic push_frame(input logic rdy, input logic [NS-1:0] v,
                            input logic [NS*SWD-1:0] d, input string extra);
    exp_t e;
    for (int n = 0; n < FBITS + TAIL; n++) begin
      e.pos = n;
      if (n >= FBITS) begin e.b = 1'b0; e.tag = "R9"; end
      else if (n == 0) begin e.b = rdy; e.tag = "R3"; end
      else if (n < TW) begin
        e.b = (n <= NS) ? v[n-1] : 1'b0;
        e.tag = "R4";
      end else begin
        int k = (n - TW) / SWD;
        int p = (n - TW) % SWD;
        e.b = v[k] ? d[k*SWD + (SWD-1-p)] : 1'b0;
        e.tag = v[k] ? "R5" : "R6";
      end
      if (!rdy) begin e.b = 1'b0; e.tag = "R7"; end
      if (extra != "") e.tag = {e.tag, "/", extra};
      q.push_back(e);
    end
  endtask

  task automatic run_frame(input logic rdy, input logic [NS-1:0] v,
                           input logic [NS*SWD-1:0] d, input bit mid_change);
    ready_i = rdy; slot_valid_i = v; slot_data_i = d;
    push_frame(rdy, v, d, mid_change ? "R8" : "R2");
    @(posedge clk); #1 sync_i = 1'b1;
    -> go;
    repeat (16) @(posedge clk);
    #1 sync_i = 1'b0;
    if (mid_change) begin
      ready_i = 1'b0; slot_valid_i = ~v; slot_data_i = ~d;
    end
    repeat (255) @(posedge clk);
  endtask

  initial begin : monitor
    forever begin
      @go;
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        @(negedge clk); #1;
        e = q.pop_front();
        check(sdata_o, e.b, e.tag, e.pos);
      end
    end
  end

  function automatic logic [NS*SWD-1:0] pattern(input int seed);
    logic [NS*SWD-1:0] r;
    for (int k = 0; k < NS; k++)
      r[k*SWD +: SWD] = 20'(32'h9E3B7 * (k + 1) + seed * 32'h1357);
    return r;
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    logic [NS*SWD-1:0] a, b;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    ready_i = 1'b1; slot_valid_i = '1; slot_data_i = '1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      check(sdata_o, 1'b0, "R1", i);
    end
    a = pattern(1);
    b = pattern(7);
    run_frame(1'b1, '1, a, 1'b0);
    run_frame(1'b1, 12'b1010_0110_0011, '1, 1'b0);
    run_frame(1'b0, '1, '1, 1'b0);
    run_frame(1'b1, '0, '1, 1'b0);
    run_frame(1'b1, 12'b0111_1000_1101, b, 1'b1);
    // inputs changed mid-frame now apply (R8)
    run_frame(ready_i, slot_valid_i, slot_data_i, 1'b0);
    repeat (8) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule